// File: doc/BRIEF.md
# Programmable Chip Select Generator

This block decodes each bus access into one of four active-low select lines and times the end of the access. Every select has a stored base address and an ignore mask. An access lands in a select when all address bits that are not ignored equal the base. The result can be narrowed further by an access-space code, and write protection can shut the select off for writes. The block also reports the data port width of the chosen region and produces an acknowledge. The acknowledge comes at once, after a programmed number of wait cycles, or when an external device acknowledges.

A small configuration port writes one whole select entry per cycle. Out of reset only select 0 is valid, and it covers the entire address space as a slow 8-bit region. A processor can therefore fetch its boot code before any programming. The outputs are registered. They are captured on the first clock edge at which the address strobe is seen high, and they are held until the strobe is seen low.

Top module: `cs_gen`

## Requirements
- R1: Reset clears all outputs (`cs_n` = 4'hF, acknowledge, error and port width low) and leaves only select 0 valid, matching every address with port width 8 bits, wait-state termination and 3 wait cycles; selects 1 to 3 are invalid.
- R2: A select matches when address bits 31:8 equal its base on every bit where its mask bit is 0; mask bits set to 1, and address bits 7:0 always, are not compared.
- R3: When a select's space-check bit is 1, it matches only if `bus_space` equals its stored 3-bit space code; when that bit is 0, the space is not examined.
- R4: A write (`bus_rd` = 0) whose winning select is write-protected drives no select and no acknowledge, and raises `cs_err` at the edge where the select would have asserted.
- R5: When several valid selects match, only the lowest-numbered one is chosen, even when it is write-protected.
- R6: A select whose valid bit is 0 never asserts; accesses in its range fall through to the next matching select.
- R7: `cs_port16` is high while the chosen select's port-width bit is 1 (16-bit port) and low for an 8-bit port.
- R8: The chosen `cs_n[i]` goes low at the first rising edge that samples `bus_as` high after it was low. Termination code 0 (fast) raises `cs_ack` at that same edge.
- R9: Termination codes 1 and 3 with wait count n (0 to 3) raise `cs_ack` n+1 edges after the select asserts.
- R10: Termination code 2 (external) raises `cs_ack` one edge after `ext_ack` is sampled high, starting with the edge after the select asserts. Once `cs_ack` is raised it stays high until the strobe drops.
- R11: With `bus_as` low at an edge, all outputs are released at that edge. While the strobe stays high, the outputs hold. An access that matches no select drives nothing.
- R12: A configuration write takes effect from the next cycle. An access already in progress keeps the termination it captured at its start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write one select entry |
| cfg_idx | input | 2 | Entry to write |
| cfg_base | input | 32 | Base address |
| cfg_mask | input | 32 | Ignore mask, 1 = bit not compared |
| cfg_space | input | 3 | Space code to require |
| cfg_space_en | input | 1 | Enable the space check |
| cfg_wprot | input | 1 | Write-protect the region |
| cfg_port16 | input | 1 | 1 = 16-bit port, 0 = 8-bit |
| cfg_term | input | 2 | 0 fast, 1/3 wait states, 2 external |
| cfg_waits | input | 2 | Number of wait cycles |
| cfg_valid | input | 1 | Entry enable |
| bus_addr | input | 32 | Access address |
| bus_space | input | 3 | Access-space code |
| bus_rd | input | 1 | 1 = read, 0 = write |
| bus_as | input | 1 | Address strobe, active high |
| ext_ack | input | 1 | External termination request |
| cs_n | output | 4 | Active-low select lines |
| cs_ack | output | 1 | Access acknowledge |
| cs_err | output | 1 | Write-protection violation |
| cs_port16 | output | 1 | Port width of the chosen region |

## Verification
The bench first runs an access under the reset configuration, which shows the boot region and its slow timing. It then programs four overlapping and disjoint regions and reaches each through addresses that separate the cases below:
- the masked bits from the compared ones;
- the ignored low byte from the base;
- a protected write from a read at the same address;
- the right space code from a wrong one;
- the lower-numbered select from a larger region that also covers the address.

Termination is exercised with the fast code, with several wait counts, and with an external acknowledge that arrives late or never. A rewrite of an entry during an access shows that the access in flight keeps its old timing and the next access uses the new one.

// File: rtl/cs_pkg.sv
package cs_pkg;
  typedef enum logic [1:0] {
    TERM_FAST  = 2'd0,
    TERM_WAIT  = 2'd1,
    TERM_EXT   = 2'd2,
    TERM_WAIT3 = 2'd3
  } term_e;
endpackage

// File: rtl/cs_regfile.sv
module cs_regfile
  import cs_pkg::*;
#(
  parameter int N_SEL = 4,
  parameter int AW = 32,
  parameter int SPW = 3,
  parameter int WSW = 2,
  parameter int BOOT_WAITS = 3,
  localparam int IW = $clog2(N_SEL)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_we,
  input  logic [IW-1:0]  cfg_idx,
  input  logic [AW-1:0]  cfg_base,
  input  logic [AW-1:0]  cfg_mask,
  input  logic [SPW-1:0] cfg_space,
  input  logic           cfg_space_en,
  input  logic           cfg_wprot,
  input  logic           cfg_port16,
  input  term_e          cfg_term,
  input  logic [WSW-1:0] cfg_waits,
  input  logic           cfg_valid,
  output logic [AW-1:0]  base_o  [N_SEL],
  output logic [AW-1:0]  mask_o  [N_SEL],
  output logic [SPW-1:0] space_o [N_SEL],
  output logic           spen_o  [N_SEL],
  output logic           wp_o    [N_SEL],
  output logic           p16_o   [N_SEL],
  output term_e          term_o  [N_SEL],
  output logic [WSW-1:0] waits_o [N_SEL],
  output logic           valid_o [N_SEL]
);
  for (genvar i = 0; i < N_SEL; i++) begin : g_entry
    localparam bit IS_BOOT = (i == 0);
    always_ff @(posedge clk) begin
      if (rst) begin
        base_o[i]  <= '0;
        mask_o[i]  <= IS_BOOT ? '1 : '0;
        space_o[i] <= '0;
        spen_o[i]  <= 1'b0;
        wp_o[i]    <= 1'b0;
        p16_o[i]   <= 1'b0;
        term_o[i]  <= TERM_WAIT;
        waits_o[i] <= WSW'(BOOT_WAITS);
        valid_o[i] <= IS_BOOT;
      end else if (cfg_we && (cfg_idx == IW'(i))) begin
        base_o[i]  <= cfg_base;
        mask_o[i]  <= cfg_mask;
        space_o[i] <= cfg_space;
        spen_o[i]  <= cfg_space_en;
        wp_o[i]    <= cfg_wprot;
        p16_o[i]   <= cfg_port16;
        term_o[i]  <= cfg_term;
        waits_o[i] <= cfg_waits;
        valid_o[i] <= cfg_valid;
      end
    end
  end
endmodule

// File: rtl/cs_match.sv
module cs_match #(
  parameter int AW = 32,
  parameter int SPW = 3,
  parameter int MIN_BLOCK_LOG2 = 8
) (
  input  logic [AW-1:0]  addr,
  input  logic [SPW-1:0] space,
  input  logic [AW-1:0]  base,
  input  logic [AW-1:0]  mask,
  input  logic [SPW-1:0] space_req,
  input  logic           space_en,
  input  logic           valid,
  output logic           hit
);
  localparam logic [AW-1:0] LOW_IGNORE = {{(AW-MIN_BLOCK_LOG2){1'b0}}, {MIN_BLOCK_LOG2{1'b1}}};

  logic [AW-1:0] diff;
  logic          addr_ok;
  logic          space_ok;

  always_comb begin
    diff     = (addr ^ base) & ~(mask | LOW_IGNORE);
    addr_ok  = (diff == '0);
    space_ok = !space_en || (space == space_req);
    hit      = valid && addr_ok && space_ok;
  end
endmodule

// File: rtl/cs_prio.sv
module cs_prio #(
  parameter int N_SEL = 4
) (
  input  logic [N_SEL-1:0] hit,
  output logic [N_SEL-1:0] grant,
  output logic             any
);
  always_comb begin
    grant = '0;
    any   = 1'b0;
    for (int i = 0; i < N_SEL; i++) begin
      if (hit[i] && !any) begin
        grant[i] = 1'b1;
        any      = 1'b1;
      end
    end
  end

  always_comb begin
    a_r5_single_grant : assert ($onehot0(grant)) else $error("R5: more than one grant");
    a_r5_grant_in_hits : assert ((grant & ~hit) == '0) else $error("R5: grant without hit");
  end
endmodule

// File: rtl/cs_term.sv
module cs_term
  import cs_pkg::*;
#(
  parameter int N_SEL = 4,
  parameter int WSW = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_as,
  input  logic             bus_rd,
  input  logic             ext_ack,
  input  logic [N_SEL-1:0] grant,
  input  logic             any,
  input  logic             sel_wp,
  input  logic             sel_p16,
  input  term_e            sel_term,
  input  logic [WSW-1:0]   sel_waits,
  output logic [N_SEL-1:0] cs_n,
  output logic             ack,
  output logic             err,
  output logic             port16
);
  logic           active;
  logic           granted;
  term_e          term_q;
  logic [WSW-1:0] waits_q;
  logic [WSW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      granted <= 1'b0;
      term_q  <= TERM_FAST;
      waits_q <= '0;
      cnt     <= '0;
      cs_n    <= '1;
      ack     <= 1'b0;
      err     <= 1'b0;
      port16  <= 1'b0;
    end else if (!bus_as) begin
      active  <= 1'b0;
      granted <= 1'b0;
      cnt     <= '0;
      cs_n    <= '1;
      ack     <= 1'b0;
      err     <= 1'b0;
      port16  <= 1'b0;
    end else if (!active) begin
      active  <= 1'b1;
      cnt     <= '0;
      term_q  <= sel_term;
      waits_q <= sel_waits;
      if (any && sel_wp && !bus_rd) begin
        err <= 1'b1;
      end else if (any) begin
        granted <= 1'b1;
        cs_n    <= ~grant;
        port16  <= sel_p16;
        ack     <= (sel_term == TERM_FAST);
      end
    end else if (granted && !ack) begin
      case (term_q)
        TERM_EXT:  ack <= ext_ack;
        TERM_FAST: ack <= 1'b1;
        default: begin
          if (cnt == waits_q) ack <= 1'b1;
          else                cnt <= cnt + 1'b1;
        end
      endcase
    end
  end

  a_r8_one_select : assert property (@(posedge clk) disable iff (rst)
    $onehot0(~cs_n));
  a_r4_err_blocks : assert property (@(posedge clk) disable iff (rst)
    err |-> (&cs_n && !ack));
  a_r9_ack_with_select : assert property (@(posedge clk) disable iff (rst)
    ack |-> !(&cs_n));
  a_r11_release : assert property (@(posedge clk) disable iff (rst)
    !bus_as |=> (&cs_n && !ack && !err && !port16));
  a_r11_hold : assert property (@(posedge clk) disable iff (rst)
    (active && bus_as) |=> $stable(cs_n));
  a_r10_ack_sticky : assert property (@(posedge clk) disable iff (rst)
    (ack && bus_as) |=> ack);
endmodule

// File: rtl/cs_gen.sv
module cs_gen
  import cs_pkg::*;
#(
  parameter int N_SEL = 4,
  parameter int AW = 32,
  parameter int SPW = 3,
  parameter int WSW = 2,
  parameter int MIN_BLOCK_LOG2 = 8,
  parameter int BOOT_WAITS = 3,
  localparam int IW = $clog2(N_SEL)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [IW-1:0]    cfg_idx,
  input  logic [AW-1:0]    cfg_base,
  input  logic [AW-1:0]    cfg_mask,
  input  logic [SPW-1:0]   cfg_space,
  input  logic             cfg_space_en,
  input  logic             cfg_wprot,
  input  logic             cfg_port16,
  input  logic [1:0]       cfg_term,
  input  logic [WSW-1:0]   cfg_waits,
  input  logic             cfg_valid,
  input  logic [AW-1:0]    bus_addr,
  input  logic [SPW-1:0]   bus_space,
  input  logic             bus_rd,
  input  logic             bus_as,
  input  logic             ext_ack,
  output logic [N_SEL-1:0] cs_n,
  output logic             cs_ack,
  output logic             cs_err,
  output logic             cs_port16
);
  logic [AW-1:0]  base  [N_SEL];
  logic [AW-1:0]  mask  [N_SEL];
  logic [SPW-1:0] space [N_SEL];
  logic           spen  [N_SEL];
  logic           wp    [N_SEL];
  logic           p16   [N_SEL];
  term_e          term  [N_SEL];
  logic [WSW-1:0] waits [N_SEL];
  logic           valid [N_SEL];

  logic [N_SEL-1:0] hit;
  logic [N_SEL-1:0] grant;
  logic             any;
  logic             sel_wp;
  logic             sel_p16;
  term_e            sel_term;
  logic [WSW-1:0]   sel_waits;

  cs_regfile #(
    .N_SEL(N_SEL), .AW(AW), .SPW(SPW), .WSW(WSW), .BOOT_WAITS(BOOT_WAITS)
  ) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_base(cfg_base), .cfg_mask(cfg_mask), .cfg_space(cfg_space),
    .cfg_space_en(cfg_space_en), .cfg_wprot(cfg_wprot), .cfg_port16(cfg_port16),
    .cfg_term(term_e'(cfg_term)), .cfg_waits(cfg_waits), .cfg_valid(cfg_valid),
    .base_o(base), .mask_o(mask), .space_o(space), .spen_o(spen), .wp_o(wp),
    .p16_o(p16), .term_o(term), .waits_o(waits), .valid_o(valid)
  );

  for (genvar i = 0; i < N_SEL; i++) begin : g_match
    cs_match #(.AW(AW), .SPW(SPW), .MIN_BLOCK_LOG2(MIN_BLOCK_LOG2)) u_match (
      .addr(bus_addr), .space(bus_space), .base(base[i]), .mask(mask[i]),
      .space_req(space[i]), .space_en(spen[i]), .valid(valid[i]), .hit(hit[i])
    );
  end

  cs_prio #(.N_SEL(N_SEL)) u_prio (.hit(hit), .grant(grant), .any(any));

  always_comb begin
    sel_wp    = 1'b0;
    sel_p16   = 1'b0;
    sel_term  = TERM_FAST;
    sel_waits = '0;
    for (int i = 0; i < N_SEL; i++) begin
      if (grant[i]) begin
        sel_wp    = wp[i];
        sel_p16   = p16[i];
        sel_term  = term[i];
        sel_waits = waits[i];
      end
    end
  end

  cs_term #(.N_SEL(N_SEL), .WSW(WSW)) u_term (
    .clk(clk), .rst(rst), .bus_as(bus_as), .bus_rd(bus_rd), .ext_ack(ext_ack),
    .grant(grant), .any(any), .sel_wp(sel_wp), .sel_p16(sel_p16),
    .sel_term(sel_term), .sel_waits(sel_waits),
    .cs_n(cs_n), .ack(cs_ack), .err(cs_err), .port16(cs_port16)
  );
endmodule

// File: tb/sim_cs_gen.sv
module sim_cs_gen;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 5000;

  logic        clk = 0;
  logic        rst = 1;
  logic        cfg_we = 0;
  logic [1:0]  cfg_idx = 0;
  logic [31:0] cfg_base = 0, cfg_mask = 0;
  logic [2:0]  cfg_space = 0;
  logic        cfg_space_en = 0, cfg_wprot = 0, cfg_port16 = 0, cfg_valid = 0;
  logic [1:0]  cfg_term = 0, cfg_waits = 0;
  logic [31:0] bus_addr = 0;
  logic [2:0]  bus_space = 0;
  logic        bus_rd = 1, bus_as = 0, ext_ack = 0;
  logic [3:0]  cs_n;
  logic        cs_ack, cs_err, cs_port16;

  cs_gen u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_base(cfg_base),
    .cfg_mask(cfg_mask), .cfg_space(cfg_space), .cfg_space_en(cfg_space_en),
    .cfg_wprot(cfg_wprot), .cfg_port16(cfg_port16), .cfg_term(cfg_term),
    .cfg_waits(cfg_waits), .cfg_valid(cfg_valid), .bus_addr(bus_addr),
    .bus_space(bus_space), .bus_rd(bus_rd), .bus_as(bus_as), .ext_ack(ext_ack),
    .cs_n(cs_n), .cs_ack(cs_ack), .cs_err(cs_err), .cs_port16(cs_port16)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string cur_req = "R1";

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Behavioural reference model
  bit [31:0] m_base [4];
  bit [31:0] m_mask [4];
  int        m_space [4];
  bit        m_spen [4], m_wp [4], m_p16 [4], m_valid [4];
  int        m_term [4], m_wait [4];
  bit [3:0]  e_cs_n = 4'hF;
  bit        e_ack = 0, e_err = 0, e_p16 = 0;
  bit        act = 0, gnt = 0, started = 0;
  int        sel_term = 0, sel_wait = 0, cnt = 0;

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      started = 1;
      for (int i = 0; i < 4; i++) begin
        m_valid[i] = 0; m_base[i] = 0; m_mask[i] = 0; m_space[i] = 0;
        m_spen[i] = 0; m_wp[i] = 0; m_p16[i] = 0; m_term[i] = 1; m_wait[i] = 3;
      end
      m_valid[0] = 1; m_mask[0] = 32'hFFFF_FFFF;
      e_cs_n = 4'hF; e_ack = 0; e_err = 0; e_p16 = 0; act = 0; gnt = 0; cnt = 0;
    end else begin
      if (!bus_as) begin
        e_cs_n = 4'hF; e_ack = 0; e_err = 0; e_p16 = 0; act = 0; gnt = 0; cnt = 0;
      end else if (!act) begin
        int win;
        win = -1;
        act = 1; cnt = 0;
        for (int i = 0; i < 4; i++) begin
          if (win < 0 && m_valid[i] &&
              (((bus_addr ^ m_base[i]) & ~m_mask[i] & 32'hFFFF_FF00) == 0) &&
              (!m_spen[i] || m_space[i] == int'(bus_space)))
            win = i;
        end
        if (win >= 0) begin
          if (m_wp[win] && !bus_rd) e_err = 1;
          else begin
            e_cs_n = ~(4'b0001 << win); gnt = 1; e_p16 = m_p16[win];
            sel_term = m_term[win]; sel_wait = m_wait[win];
            e_ack = (sel_term == 0);
          end
        end
      end else if (gnt && !e_ack) begin
        if (sel_term == 2) e_ack = ext_ack;
        else if (cnt == sel_wait) e_ack = 1;
        else cnt++;
      end
      if (cfg_we) begin
        m_base[cfg_idx] = cfg_base; m_mask[cfg_idx] = cfg_mask;
        m_space[cfg_idx] = int'(cfg_space); m_spen[cfg_idx] = cfg_space_en;
        m_wp[cfg_idx] = cfg_wprot; m_p16[cfg_idx] = cfg_port16;
        m_term[cfg_idx] = int'(cfg_term); m_wait[cfg_idx] = int'(cfg_waits);
        m_valid[cfg_idx] = cfg_valid;
      end
    end
    if (cycles > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (started) begin
      chk(cs_n === e_cs_n, cur_req, "cs_n vs model", 32'(cs_n), 32'(e_cs_n));
      chk(cs_ack === e_ack, cur_req, "ack vs model", 32'(cs_ack), 32'(e_ack));
      chk(cs_err === e_err, cur_req, "err vs model", 32'(cs_err), 32'(e_err));
      chk(cs_port16 === e_p16, cur_req, "port16 vs model", 32'(cs_port16), 32'(e_p16));
    end
  end

  task automatic cfg(input int idx, input [31:0] b, input [31:0] m, input int sp,
                     input bit spen, input bit wp, input bit p16, input int term,
                     input int w, input bit v);
    @(negedge clk);
    cfg_we = 1; cfg_idx = 2'(idx); cfg_base = b; cfg_mask = m; cfg_space = 3'(sp);
    cfg_space_en = spen; cfg_wprot = wp; cfg_port16 = p16; cfg_term = 2'(term);
    cfg_waits = 2'(w); cfg_valid = v;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic access(input [31:0] a, input int sp, input bit rd, input int ext_at,
                        input int exp_sel, input int exp_lat, input bit exp_err,
                        input bit exp_p16, input string req);
    int first_ack;
    logic [3:0] exp_cs;
    first_ack = -1;
    exp_cs = (exp_sel < 0) ? 4'hF : ~(4'b0001 << exp_sel);
    cur_req = req;
    @(negedge clk);
    bus_addr = a; bus_space = 3'(sp); bus_rd = rd; bus_as = 1; ext_ack = 0;
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      if (k == 1) begin
        chk(cs_n === exp_cs, req, "select at strobe edge", 32'(cs_n), 32'(exp_cs));
        chk(cs_err === exp_err, req, "error flag", 32'(cs_err), 32'(exp_err));
        if (exp_sel >= 0)
          chk(cs_port16 === exp_p16, "R7", "port width", 32'(cs_port16), 32'(exp_p16));
      end
      if (cs_ack === 1'b1 && first_ack < 0) first_ack = k;
      if (k == ext_at) ext_ack = 1;
    end
    chk(first_ack == exp_lat, req, "ack latency", 32'(first_ack), 32'(exp_lat));
    bus_as = 0; ext_ack = 0;
    @(negedge clk);
    chk(cs_n === 4'hF && !cs_ack && !cs_err && !cs_port16, "R11", "release",
        {cs_n, 1'b0, cs_ack, cs_err, cs_port16}, 32'hF0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    cur_req = "R1";
    chk(cs_n === 4'hF && !cs_ack && !cs_err && !cs_port16, "R1", "reset outputs",
        {cs_n, 1'b0, cs_ack, cs_err, cs_port16}, 32'hF0);
    // R1 boot region: any address, 8-bit, 3 waits -> ack seen at k=5
    access(32'hDEAD_BEEF, 0, 1, 0, 0, 5, 0, 0, "R1");

    cur_req = "R12";
    cfg(1, 32'h0010_0000, 32'h0000_0FFF, 0, 0, 1, 0, 1, 1, 1);
    cfg(2, 32'h0010_0000, 32'h000F_FFFF, 0, 0, 0, 1, 1, 2, 1);
    cfg(3, 32'h8000_00AB, 32'h0FFF_FFFF, 5, 1, 0, 0, 2, 0, 1);
    cfg(0, 32'h0000_0000, 32'h0000_FFFF, 0, 0, 0, 1, 0, 0, 1);

    access(32'h0000_FF7F, 0, 1, 0, 0, 1, 0, 1, "R8");   // fast, 16-bit
    access(32'h0001_0000, 0, 1, 0, -1, -1, 0, 0, "R2"); // outside cs0, no match
    access(32'h9000_0000, 5, 1, 0, -1, -1, 0, 0, "R2"); // bit 28 compared
    access(32'h0010_0100, 0, 1, 0, 1, 3, 0, 0, "R5");   // cs1 beats cs2
    access(32'h0010_0100, 0, 0, 0, -1, -1, 1, 0, "R4"); // protected write
    access(32'h0010_2000, 0, 0, 0, 2, 4, 0, 1, "R9");   // 2 waits
    access(32'h8FFF_FF00, 5, 1, 3, 3, 4, 0, 0, "R10");  // external at k=3
    access(32'h8000_0010, 5, 1, 0, 3, -1, 0, 0, "R10"); // no external ack
    access(32'h8000_0000, 1, 1, 0, -1, -1, 0, 0, "R3"); // wrong space
    access(32'h8000_0000, 5, 1, 2, 3, 3, 0, 0, "R3");   // right space, low byte ignored

    cur_req = "R6";
    cfg(1, 32'h0010_0000, 32'h0000_0FFF, 0, 0, 1, 0, 1, 1, 0);
    access(32'h0010_0100, 0, 0, 0, 2, 4, 0, 1, "R6");   // falls to cs2

    // R12: rewrite cs2 to fast during an access; old timing kept
    cur_req = "R12";
    begin
      int first_ack;
      first_ack = -1;
      @(negedge clk);
      bus_addr = 32'h0010_3000; bus_space = 0; bus_rd = 1; bus_as = 1;
      for (int k = 1; k <= 8; k++) begin
        @(negedge clk);
        if (k == 1) begin
          cfg_we = 1; cfg_idx = 2; cfg_base = 32'h0010_0000; cfg_mask = 32'h000F_FFFF;
          cfg_space = 0; cfg_space_en = 0; cfg_wprot = 0; cfg_port16 = 1;
          cfg_term = 0; cfg_waits = 0; cfg_valid = 1;
        end else cfg_we = 0;
        if (cs_ack === 1'b1 && first_ack < 0) first_ack = k;
      end
      chk(first_ack == 4, "R12", "in-flight ack latency", 32'(first_ack), 32'd4);
      bus_as = 0;
      @(negedge clk);
    end
    access(32'h0010_3000, 0, 1, 0, 2, 1, 0, 1, "R12");  // new config: fast

    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule